// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block joins two buses, A and B, in both directions. Each direction has a storage register. The register takes a snapshot of the source bus on the rising edge of that direction's capture strobe. Each output can show either the live data on the opposite bus or the value held in the register. The tri-state pins are modelled as three separate vectors per bus: input data, output data and output enable. Board-level logic combines these into pads.

The 18 bits are split into two 9-bit halves. Each half has its own capture strobe, source select and output enable for each direction. When the gang input is set, the controls of half 0 steer both halves, so the block acts as one 18-bit path. The A-to-B output enable is active high. The B-to-A output enable is active low. A test-mode input blocks captures and turns off every output enable. A per-half contention flag goes high when both directions of a half are enabled at once.

The capture strobes are sampled on the block clock. A rising edge seen on one clock edge loads the register on that same edge.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: A low-to-high change on the effective A-to-B capture strobe of a half, sampled on a `clk` edge, loads that half's A-to-B register with `a_in` on that same edge.
- R2: While the effective A-to-B select of a half is 0, that half of `b_out` equals the live `a_in` of the same half, with no clock delay.
- R3: While the effective A-to-B select of a half is 1, that half of `b_out` equals the stored A-to-B register of that half.
- R4: Every bit of a half of `b_oe` is 1 when that half's effective `oe_ab` is 1 and test mode is off. Otherwise every bit is 0.
- R5: The B-to-A path mirrors R1 to R3, using `cap_ba`, `sel_ba` and `b_in`, and drives `a_out`.
- R6: Every bit of a half of `a_oe` is 1 when that half's effective `oe_ba_n` is 0 and test mode is off. Otherwise every bit is 0.
- R7: A register holds its value on every clock edge without a fresh rising edge of its strobe, including while the strobe stays high. A synchronous `rst` clears both registers to zero.
- R8: With `gang` at 0, each half uses its own control bits. With `gang` at 1, the control bits of half 0 govern all halves, and the control bits of the other halves are ignored.
- R9: While `test_mode` is 1, no register captures, and `a_oe` and `b_oe` are all zero.
- R10: `contend[h]` is 1 exactly when the output enables of half h are active in both directions at once. Both outputs are still driven as commanded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the capture strobes |
| rst | input | 1 | Synchronous reset, active high |
| test_mode | input | 1 | Blocks captures and output enables |
| gang | input | 1 | 1: half 0 controls steer all halves |
| a_in | input | 18 | Data read from the A bus |
| b_in | input | 18 | Data read from the B bus |
| cap_ab | input | 2 | A-to-B capture strobe per half |
| cap_ba | input | 2 | B-to-A capture strobe per half |
| sel_ab | input | 2 | A-to-B source per half: 0 live, 1 stored |
| sel_ba | input | 2 | B-to-A source per half: 0 live, 1 stored |
| oe_ab | input | 2 | B output enable per half, active high |
| oe_ba_n | input | 2 | A output enable per half, active low |
| a_out | output | 18 | Data driven toward the A bus |
| a_oe | output | 18 | Per-bit enable for `a_out` |
| b_out | output | 18 | Data driven toward the B bus |
| b_oe | output | 18 | Per-bit enable for `b_out` |
| contend | output | 2 | Both directions enabled on a half |

## Verification
The assertions are checked on every cycle. They confirm that each register captures the source bus on a strobe rising edge and otherwise holds, that test mode silences every enable, that each half's enable is all ones or all zeros, and that a contention flag never appears without both enables. The bench scenarios are the only place the following are shown: how the live and stored sources are chosen, the opposite enable polarities, the effect of gang mode on both halves, a strobe held high across many edges, and reset clearing stored data. To do this the bench sweeps every combination of select, enable, gang and test mode against a bench-side model of the stored values.

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int HALF_W = 9,
  parameter int HALVES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       test_mode,
  input  logic                       gang,
  input  logic [HALF_W*HALVES-1:0]   a_in,
  input  logic [HALF_W*HALVES-1:0]   b_in,
  input  logic [HALVES-1:0]          cap_ab,
  input  logic [HALVES-1:0]          cap_ba,
  input  logic [HALVES-1:0]          sel_ab,
  input  logic [HALVES-1:0]          sel_ba,
  input  logic [HALVES-1:0]          oe_ab,
  input  logic [HALVES-1:0]          oe_ba_n,
  output logic [HALF_W*HALVES-1:0]   a_out,
  output logic [HALF_W*HALVES-1:0]   a_oe,
  output logic [HALF_W*HALVES-1:0]   b_out,
  output logic [HALF_W*HALVES-1:0]   b_oe,
  output logic [HALVES-1:0]          contend
);
  localparam int W = HALF_W * HALVES;

  logic [HALVES-1:0] k_cab, k_cba, k_sab, k_sba, k_oab, k_oba;
  logic [HALVES-1:0] cab_q, cba_q;
  logic [HALF_W-1:0] st_ab [HALVES];
  logic [HALF_W-1:0] st_ba [HALVES];

  always_ff @(posedge clk) begin
    if (rst) begin
      cab_q <= '0;
      cba_q <= '0;
    end else begin
      cab_q <= k_cab;
      cba_q <= k_cba;
    end
  end

  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> (a_oe == '0 && b_oe == '0)); // R9

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam int LO = h * HALF_W;

    assign k_cab[h] = gang ? cap_ab[0] : cap_ab[h];
    assign k_cba[h] = gang ? cap_ba[0] : cap_ba[h];
    assign k_sab[h] = gang ? sel_ab[0] : sel_ab[h];
    assign k_sba[h] = gang ? sel_ba[0] : sel_ba[h];
    assign k_oab[h] = !test_mode && (gang ? oe_ab[0] : oe_ab[h]);
    assign k_oba[h] = !test_mode && !(gang ? oe_ba_n[0] : oe_ba_n[h]);

    always_ff @(posedge clk) begin
      if (rst) begin
        st_ab[h] <= '0;
        st_ba[h] <= '0;
      end else if (!test_mode) begin
        if (k_cab[h] && !cab_q[h]) st_ab[h] <= a_in[LO +: HALF_W];
        if (k_cba[h] && !cba_q[h]) st_ba[h] <= b_in[LO +: HALF_W];
      end
    end

    assign b_out[LO +: HALF_W] = k_sab[h] ? st_ab[h] : a_in[LO +: HALF_W];
    assign a_out[LO +: HALF_W] = k_sba[h] ? st_ba[h] : b_in[LO +: HALF_W];
    assign b_oe[LO +: HALF_W]  = {HALF_W{k_oab[h]}};
    assign a_oe[LO +: HALF_W]  = {HALF_W{k_oba[h]}};
    assign contend[h]          = k_oab[h] & k_oba[h];

    AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (rst)
      (k_cab[h] && !cab_q[h] && !test_mode) |=> st_ab[h] == $past(a_in[LO +: HALF_W])); // R1
    AST_CAPTURE_BA: assert property (@(posedge clk) disable iff (rst)
      (k_cba[h] && !cba_q[h] && !test_mode) |=> st_ba[h] == $past(b_in[LO +: HALF_W])); // R5
    AST_HOLD_AB: assert property (@(posedge clk) disable iff (rst)
      (!k_cab[h] || cab_q[h] || test_mode) |=> $stable(st_ab[h])); // R7
    AST_HOLD_BA: assert property (@(posedge clk) disable iff (rst)
      (!k_cba[h] || cba_q[h] || test_mode) |=> $stable(st_ba[h])); // R7
    AST_OE_WHOLE: assert property (@(posedge clk) disable iff (rst)
      ($countones(b_oe[LO +: HALF_W]) == 0 || $countones(b_oe[LO +: HALF_W]) == HALF_W)); // R4
    AST_CONTEND: assert property (@(posedge clk) disable iff (rst)
      contend[h] |-> (a_oe[LO] && b_oe[LO])); // R10
  end
endmodule

// File: tb/sim_bidir_reg_xcvr.sv
module sim_bidir_reg_xcvr;
  localparam int HW = 9;
  localparam int NH = 2;
  localparam int W = HW * NH;

  logic clk = 0, rst = 1, test_mode = 0, gang = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [NH-1:0] cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0, oe_ab = '0, oe_ba_n = '1;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [NH-1:0] contend;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  bidir_reg_xcvr #(.HALF_W(HW), .HALVES(NH)) u0 (
    .clk(clk), .rst(rst), .test_mode(test_mode), .gang(gang), .a_in(a_in), .b_in(b_in),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab),
    .oe_ba_n(oe_ba_n), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe), .contend(contend));

  task automatic check_all(input string req);
    logic [W-1:0] eb, ea, ebo, eao;
    logic [NH-1:0] ec;
    for (int h = 0; h < NH; h++) begin
      int s = gang ? 0 : h;
      eb[h*HW +: HW]  = sel_ab[s] ? m_ab[h*HW +: HW] : a_in[h*HW +: HW];
      ea[h*HW +: HW]  = sel_ba[s] ? m_ba[h*HW +: HW] : b_in[h*HW +: HW];
      ebo[h*HW +: HW] = (!test_mode && oe_ab[s]) ? '1 : '0;
      eao[h*HW +: HW] = (!test_mode && !oe_ba_n[s]) ? '1 : '0;
      ec[h] = !test_mode && oe_ab[s] && !oe_ba_n[s];
    end
    checks++;
    if (b_out !== eb || a_out !== ea || b_oe !== ebo || a_oe !== eao || contend !== ec) begin
      errors++;
      $display("FAIL %s: b_out=%h/%h a_out=%h/%h b_oe=%h/%h a_oe=%h/%h contend=%b/%b",
               req, b_out, eb, a_out, ea, b_oe, ebo, a_oe, eao, contend, ec);
    end
  endtask

  task automatic pulse(input logic [NH-1:0] mab, input logic [NH-1:0] mba);
    @(negedge clk);
    cap_ab = mab; cap_ba = mba;
    @(posedge clk);
    if (!test_mode)
      for (int h = 0; h < NH; h++) begin
        int s = gang ? 0 : h;
        if (mab[s]) m_ab[h*HW +: HW] = a_in[h*HW +: HW];
        if (mba[s]) m_ba[h*HW +: HW] = b_in[h*HW +: HW];
      end
    @(negedge clk);
    cap_ab = '0; cap_ba = '0;
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0;
    #1 check_all("R7 reset clears registers");

    a_in = 18'h2A5C3; b_in = 18'h1B7E4;
    pulse(2'b01, 2'b00);
    #1 check_all("R1 R8 half0-only capture A-to-B");
    pulse(2'b00, 2'b10);
    #1 check_all("R5 R8 half1-only capture B-to-A");

    @(negedge clk); cap_ab = 2'b11; a_in = 18'h0F0F0;
    @(posedge clk); m_ab = 18'h0F0F0;
    @(negedge clk); a_in = 18'h3FFFF;
    repeat (4) @(negedge clk);
    #1 check_all("R7 strobe held high, no recapture");
    cap_ab = '0;

    test_mode = 1; a_in = 18'h12345; b_in = 18'h23456;
    pulse(2'b11, 2'b11);
    #1 check_all("R9 test mode blocks capture and enables");
    test_mode = 0;
    #1 check_all("R9 stored values survive test mode");

    gang = 1; a_in = 18'h1C71C; b_in = 18'h0E38E;
    pulse(2'b01, 2'b01);
    #1 check_all("R8 gang capture via half 0 strobes");
    gang = 0;

    a_in = 18'h15A5A; b_in = 18'h2C3C3;
    for (int c = 0; c < 1024; c++) begin
      @(negedge clk);
      {test_mode, gang, sel_ab, sel_ba, oe_ab, oe_ba_n} = c[9:0];
      a_in = a_in ^ 18'(c * 37);
      b_in = b_in ^ 18'(c * 91);
      #1 check_all("R2 R3 R4 R5 R6 R8 R9 R10 sweep");
    end
    test_mode = 0; gang = 0;

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; m_ab = '0; m_ba = '0;
    sel_ab = '1; sel_ba = '1;
    #1 check_all("R7 mid-run reset clears registers");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule